// File: doc/BRIEF.md
# Proximity Threshold Interrupt Filter

This block sits behind a proximity converter and decides when a finished measurement has to interrupt the host. On each conversion-done strobe it compares the new 16-bit result with a programmable lower and upper limit. Each limit is supplied as two register bytes. A consecutive-count persistence filter then decides whether the result raises an interrupt. The interrupt is held until software sends a clear command. It drives an open-drain, active-low pin, so the block outputs a pull-down enable rather than a pin level.

The persistence setting is a 4-bit field. A setting of zero interrupts on every finished conversion, whatever the limits are. Any other setting N requires N out-of-range results in a row. The block also gives the register file two status bits: one says an interrupt is being asserted, and one says at least one result has been converted since reset.

Top module: `prox_irq_filter`

## Requirements
- R1: The lower limit is `{lo_thr_hi_byte, lo_thr_lo_byte}` and the upper limit is `{hi_thr_hi_byte, hi_thr_lo_byte}`. The high-byte input supplies bits 15:8 of each limit.
- R2: A result is out of range only if it is strictly less than the lower limit or strictly greater than the upper limit. A result equal to either limit is in range.
- R3: The persistence setting is bits 7:4 of `persist_reg`, and bits 3:0 are ignored. A setting of 0 makes every conversion-done strobe qualify, whatever the result.
- R4: For a setting N from 1 to 15, a strobe qualifies when its result is the Nth or later out-of-range result in a row. Any in-range result returns the count to zero.
- R5: The consecutive count saturates at 15 and does not wrap. After 20 out-of-range results, the next out-of-range result still qualifies for N=15.
- R6: Once asserted, `irq_pull_low` and `stat_irq` stay high until `irq_clear` is pulsed. In-range results do not drop them. A clear pulse with no strobe in the same cycle drops both one clock later and returns the consecutive count to zero.
- R7: If `irq_clear` and a qualifying strobe arrive in the same cycle, the interrupt stays asserted.
- R8: A qualifying strobe latches the interrupt only while `irq_en` is 1. While `irq_en` is 0, `irq_pull_low` and `stat_irq` are 0.
- R9: `stat_valid` is 0 after reset. It goes to 1 one clock after the first conversion-done strobe and stays at 1 until reset.
- R10: After reset, `irq_pull_low`, `stat_irq` and `stat_valid` are all 0.
- R11: Changes of the result or the limits with no strobe have no effect on the interrupt or on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a new result is available |
| result | input | 16 | Converted proximity value |
| lo_thr_lo_byte | input | 8 | Lower limit, bits 7:0 |
| lo_thr_hi_byte | input | 8 | Lower limit, bits 15:8 |
| hi_thr_lo_byte | input | 8 | Upper limit, bits 7:0 |
| hi_thr_hi_byte | input | 8 | Upper limit, bits 15:8 |
| persist_reg | input | 8 | Persistence register; bits 7:4 are the setting |
| irq_en | input | 1 | Interrupt enable |
| irq_clear | input | 1 | One-cycle clear pulse from the command decoder |
| irq_pull_low | output | 1 | 1 = pull the open-drain interrupt pin low |
| stat_irq | output | 1 | Status: an interrupt is being asserted |
| stat_valid | output | 1 | Status: at least one result has been converted |

## Verification
The hardest state to reach is a saturated consecutive count. While the interrupt is pending its effect cannot be seen, and a clear resets the count. The stimulus therefore holds `irq_en` low through 20 out-of-range results, then enables and sends a single result that must fire. The collision of a clear pulse with a qualifying strobe is timed directly by driving both in the same cycle.

// File: rtl/prox_irq_pkg.sv
package prox_irq_pkg;
  // Saturating increment of an unsigned count.
  function automatic logic [3:0] sat_inc4(input logic [3:0] v);
    return (v == 4'hF) ? v : v + 4'd1;
  endfunction
endpackage

// File: rtl/prox_thr_compare.sv
module prox_thr_compare #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic [NBYTES*BYTE_W-1:0] result,
  input  logic [NBYTES*BYTE_W-1:0] lo_bytes,
  input  logic [NBYTES*BYTE_W-1:0] hi_bytes,
  output logic                     out_of_range
);
  localparam int DATA_W = NBYTES * BYTE_W;

  logic [DATA_W-1:0] lo_word;
  logic [DATA_W-1:0] hi_word;

  // Byte k of the packed byte bus lands in word bits [k*BYTE_W +: BYTE_W].
  for (genvar k = 0; k < NBYTES; k++) begin : g_assemble
    assign lo_word[k*BYTE_W +: BYTE_W] = lo_bytes[k*BYTE_W +: BYTE_W];
    assign hi_word[k*BYTE_W +: BYTE_W] = hi_bytes[k*BYTE_W +: BYTE_W];
  end

  logic below;
  logic above;
  always_comb begin
    below        = result < lo_word;
    above        = result > hi_word;
    out_of_range = below | above;
  end
endmodule

// File: rtl/prox_persist_count.sv
module prox_persist_count
  import prox_irq_pkg::*;
#(
  parameter int PERS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic              out_of_range,
  input  logic [PERS_W-1:0] pers,
  input  logic              clear,
  output logic              qualify
);
  logic [PERS_W-1:0] cnt_q;
  logic [PERS_W-1:0] cnt_d;
  logic [PERS_W-1:0] cnt_inc;
  logic              cnt_en;

  always_comb begin
    cnt_inc = sat_inc4(cnt_q);
    cnt_en  = conv_done | clear;
    if (conv_done)
      cnt_d = out_of_range ? cnt_inc : '0;
    else
      cnt_d = '0;
    qualify = conv_done &
              ((pers == '0) | (out_of_range & (cnt_inc >= pers)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/prox_irq_latch.sv
module prox_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic qualify,
  input  logic irq_en,
  input  logic clear,
  input  logic conv_done,
  output logic pending,
  output logic data_valid
);
  logic pend_d;
  logic pend_en;
  logic valid_en;

  always_comb begin
    pend_en  = (qualify & irq_en) | clear;
    pend_d   = qualify & irq_en;
    valid_en = conv_done & ~data_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pending <= 1'b0;
    else if (pend_en)
      pending <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_valid <= 1'b0;
    else if (valid_en)
      data_valid <= 1'b1;
  end
endmodule

// File: rtl/prox_irq_filter.sv
module prox_irq_filter #(
  parameter int BYTE_W   = 8,
  parameter int PERS_W   = 4,
  parameter int PERS_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [2*BYTE_W-1:0] result,
  input  logic [BYTE_W-1:0] lo_thr_lo_byte,
  input  logic [BYTE_W-1:0] lo_thr_hi_byte,
  input  logic [BYTE_W-1:0] hi_thr_lo_byte,
  input  logic [BYTE_W-1:0] hi_thr_hi_byte,
  input  logic [BYTE_W-1:0] persist_reg,
  input  logic              irq_en,
  input  logic              irq_clear,
  output logic              irq_pull_low,
  output logic              stat_irq,
  output logic              stat_valid
);
  localparam int NBYTES = 2;

  logic              oor;
  logic              qualify;
  logic              pending;
  logic [PERS_W-1:0] pers;

  assign pers = persist_reg[PERS_LSB +: PERS_W];

  prox_thr_compare #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_cmp (
    .result       (result),
    .lo_bytes     ({lo_thr_hi_byte, lo_thr_lo_byte}),
    .hi_bytes     ({hi_thr_hi_byte, hi_thr_lo_byte}),
    .out_of_range (oor)
  );

  prox_persist_count #(.PERS_W(PERS_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_done    (conv_done),
    .out_of_range (oor),
    .pers         (pers),
    .clear        (irq_clear),
    .qualify      (qualify)
  );

  prox_irq_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .qualify    (qualify),
    .irq_en     (irq_en),
    .clear      (irq_clear),
    .conv_done  (conv_done),
    .pending    (pending),
    .data_valid (stat_valid)
  );

  always_comb begin
    irq_pull_low = pending & irq_en;
    stat_irq     = pending & irq_en;
  end
endmodule

// File: rtl/prox_irq_filter_chk.sv
module prox_irq_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        conv_done,
  input logic [15:0] result,
  input logic [7:0]  lo_thr_lo_byte,
  input logic [7:0]  lo_thr_hi_byte,
  input logic [7:0]  hi_thr_lo_byte,
  input logic [7:0]  hi_thr_hi_byte,
  input logic [7:0]  persist_reg,
  input logic        irq_en,
  input logic        irq_clear,
  input logic        irq_pull_low,
  input logic        stat_irq,
  input logic        stat_valid
);
  logic in_rng;
  assign in_rng = (result >= {lo_thr_hi_byte, lo_thr_lo_byte}) &&
                  (result <= {hi_thr_hi_byte, hi_thr_lo_byte});

  assert_every_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && persist_reg[7:4] == 4'd0 && irq_en) |=> (irq_pull_low && stat_irq));

  assert_inrange_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && in_rng && persist_reg[7:4] != 4'd0 && !stat_irq && irq_en) |=> !stat_irq);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_irq && !irq_clear) |=> (stat_irq || !irq_en));

  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !conv_done) |=> !stat_irq);

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> (!irq_pull_low && !stat_irq));

  assert_valid_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> stat_valid);

  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> stat_valid);

  assert_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !stat_irq && irq_en && !$rose(irq_en)) |=> !stat_irq);
endmodule

bind prox_irq_filter prox_irq_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .result(result),
  .lo_thr_lo_byte(lo_thr_lo_byte), .lo_thr_hi_byte(lo_thr_hi_byte),
  .hi_thr_lo_byte(hi_thr_lo_byte), .hi_thr_hi_byte(hi_thr_hi_byte),
  .persist_reg(persist_reg), .irq_en(irq_en), .irq_clear(irq_clear),
  .irq_pull_low(irq_pull_low), .stat_irq(stat_irq), .stat_valid(stat_valid)
);

// File: tb/prox_irq_filter_test.sv
module prox_irq_filter_test;
  logic        clk;
  logic        rst_n;
  logic        conv_done;
  logic [15:0] result;
  logic [7:0]  lo_lsb, lo_msb, hi_lsb, hi_msb;
  logic [7:0]  persist_reg;
  logic        irq_en;
  logic        irq_clear;
  logic        irq_pull_low, stat_irq, stat_valid;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  prox_irq_filter uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .result(result),
    .lo_thr_lo_byte(lo_lsb), .lo_thr_hi_byte(lo_msb),
    .hi_thr_lo_byte(hi_lsb), .hi_thr_hi_byte(hi_msb),
    .persist_reg(persist_reg), .irq_en(irq_en), .irq_clear(irq_clear),
    .irq_pull_low(irq_pull_low), .stat_irq(stat_irq), .stat_valid(stat_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector: {clear_first[1], result[16], pers[4], expected_irq[1]}
  // Limits fixed: lower 0x0120, upper 0x0345.
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 16'h0200, 4'd1, 1'b0},  // R1 in range (swapped bytes would fire)
    {1'b0, 16'h011F, 4'd1, 1'b1},  // R2 one below lower
    {1'b1, 16'h0120, 4'd1, 1'b0},  // R2 equal lower
    {1'b0, 16'h0345, 4'd1, 1'b0},  // R2 equal upper
    {1'b0, 16'h0346, 4'd1, 1'b1},  // R2 one above upper
    {1'b1, 16'h0400, 4'd3, 1'b0},  // R4 count 1
    {1'b0, 16'h0010, 4'd3, 1'b0},  // R4 count 2
    {1'b0, 16'h0200, 4'd3, 1'b0},  // R4 in range resets
    {1'b0, 16'h0400, 4'd3, 1'b0},  // R4 count 1
    {1'b0, 16'h0400, 4'd3, 1'b0},  // R4 count 2
    {1'b0, 16'h0400, 4'd3, 1'b1},  // R4 count 3 fires
    {1'b1, 16'h0200, 4'd0, 1'b1}   // R3 setting 0 fires in range
  };

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic set_pers(input logic [3:0] p);
    persist_reg = {p, 4'b1010};  // low nibble must be ignored (R3)
  endtask

  task automatic pulse_clear();
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
  endtask

  task automatic convert(input logic [15:0] v);
    @(negedge clk); result = v; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; conv_done = 1'b0; result = '0; irq_en = 1'b1; irq_clear = 1'b0;
    lo_lsb = 8'h20; lo_msb = 8'h01; hi_lsb = 8'h45; hi_msb = 8'h03;
    set_pers(4'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_pull_low, 1'b0, "R10 pin");
    check(stat_irq, 1'b0, "R10 status irq");
    check(stat_valid, 1'b0, "R10/R9 valid");

    // R11: result moves, setting 0, but no strobe
    set_pers(4'd0);
    result = 16'h0001; @(negedge clk); result = 16'hFFFF; @(negedge clk);
    check(stat_irq, 1'b0, "R11 no strobe");
    check(stat_valid, 1'b0, "R11/R9 valid without strobe");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) pulse_clear();
      set_pers(VEC[i][4:1]);
      convert(VEC[i][20:5]);
      check(irq_pull_low, VEC[i][0], $sformatf("R1-vector %0d pin (R2 R3 R4)", i));
      check(stat_irq, VEC[i][0], $sformatf("vector %0d status", i));
    end
    check(stat_valid, 1'b1, "R9 valid after conversions");

    // R6: sticky through in-range results, then clear
    set_pers(4'd1);
    convert(16'h0200); convert(16'h0200);
    check(irq_pull_low, 1'b1, "R6 sticky");
    pulse_clear();
    check(irq_pull_low, 1'b0, "R6 clear drops pin");
    check(stat_irq, 1'b0, "R6 clear drops status");

    // R6: clear resets count (setting 2)
    set_pers(4'd2);
    convert(16'h0400);
    pulse_clear();
    convert(16'h0400);
    check(stat_irq, 1'b0, "R6 clear reset count");
    convert(16'h0400);
    check(stat_irq, 1'b1, "R6 count after clear fires");

    // R7: clear and qualifying strobe together
    set_pers(4'd0);
    @(negedge clk); result = 16'h0200; conv_done = 1'b1; irq_clear = 1'b1;
    @(negedge clk); conv_done = 1'b0; irq_clear = 1'b0;
    check(stat_irq, 1'b1, "R7 event wins");
    pulse_clear();
    check(stat_irq, 1'b0, "R7 cleared afterwards");

    // R8: disabled events are not latched
    irq_en = 1'b0;
    convert(16'h0200);
    check(irq_pull_low, 1'b0, "R8 pin off while disabled");
    irq_en = 1'b1;
    @(negedge clk);
    check(stat_irq, 1'b0, "R8 no latch while disabled");
    convert(16'h0200);
    check(irq_pull_low, 1'b1, "R8 enabled fires");
    pulse_clear();

    // R5: saturation with interrupt disabled
    set_pers(4'd15);
    irq_en = 1'b0;
    for (int k = 0; k < 20; k++) convert(16'h0400);
    irq_en = 1'b1;
    @(negedge clk);
    check(stat_irq, 1'b0, "R5 nothing pending");
    convert(16'h0400);
    check(stat_irq, 1'b1, "R5 saturated count still qualifies");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule